// File: doc/BRIEF.md
# Scrypt ROMix Memory-Hard Sequencer

This block runs the memory-hard mixing stage of scrypt with cost N = 1024 and block factor r = 1, working on a single 1024-bit state. A start pulse loads the input state. The block then runs two phases of N steps each. In the filling phase it records every state in an internal scratchpad before passing that state to an external BlockMix unit. In the gathering phase it takes a scratchpad index from a 10-bit slice of the current state, reads that entry, folds it into the state with XOR, and passes the result to BlockMix again.

The BlockMix unit sits outside the block. The two are linked by a request/acknowledge pair: the request holds its data steady until the acknowledge arrives, and the acknowledge returns the mixed result in the same cycle. Only one request is outstanding at any time. The scratchpad is an inferred RAM whose read output is registered. A parameter selects one of two fold styles. In the first, a pipeline register holds the XOR result. In the second, the XOR feeds the request data straight from the RAM output.

Top module: `romix_ctrl`

## Requirements
- R1: After reset `done` and `mix_req` are low and stay low until `start` is seen while idle.
- R2: `start` sampled high while idle loads `blk_in`, and the first BlockMix request carries that value unchanged.
- R3: In the filling phase, request k+1 (k < N-1) carries the result returned for request k.
- R4: In the gathering phase, each request carries S XOR E. S is the current state. E is the scratchpad entry whose index is bits 489:480 of S, read as an unsigned number with bit 480 as its LSB.
- R5: Scratchpad entry i holds the data of filling-phase request i, meaning the state before it was mixed.
- R6: One operation issues exactly 2N = 2048 requests. `done` rises in the cycle after the last acknowledge is accepted, and `blk_out` then equals the last returned result.
- R7: `done` is high for exactly one cycle per operation.
- R8: After `done`, `blk_out` keeps its value until the next accepted `start`, whatever `blk_in` does.
- R9: A raised `mix_req` stays high with stable `mix_data` until `mix_ack` is seen.
- R10: `start` while an operation is running has no effect on the requests or on the result.
- R11: The result does not depend on how many cycles each acknowledge takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted only while idle) |
| blk_in | input | 1024 | Initial working state |
| done | output | 1 | One-cycle completion pulse |
| blk_out | output | 1024 | Final state, held until next accepted start |
| mix_req | output | 1 | BlockMix request |
| mix_data | output | 1024 | State passed to BlockMix |
| mix_ack | input | 1 | BlockMix acknowledge, valid with `mix_res` |
| mix_res | input | 1024 | BlockMix result |

## Verification
The assertions assume that `mix_ack` is raised only while `mix_req` is high, and that it lasts one cycle per request with `mix_res` valid in that cycle. The bench's BlockMix responder meets this. It waits at a falling edge for a request, holds back its acknowledge for zero, two or a random number of cycles, and then pulses the acknowledge for one cycle with a mixing function of its own. The bench raises `start` during a run only to show that the pulse is ignored. A golden model in the bench computes the full sequence of 2048 requests from the input state, and each request is popped and compared as it appears.

// File: rtl/romix_pkg.sv
package romix_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_FILL = 3'd1,
      ST_ADDR = 3'd2,
      ST_FOLD = 3'd3,
      ST_MIX  = 3'd4,
      ST_DONE = 3'd5
   } romix_fsm_e;

endpackage

// File: rtl/romix_scratchpad.sv
module romix_scratchpad #(
   parameter int DW = 1024,
   parameter int AW = 10
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          rd_en,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (rd_en) rdata <= mem[raddr];
   end
endmodule

// File: rtl/romix_step_counter.sv
module romix_step_counter #(
   parameter int AW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   output logic [AW-1:0] count,
   output logic          last
);
   localparam logic [AW-1:0] TOP = {AW{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (clr) count <= '0;
      else if (inc) count <= count + 1'b1;
   end

   assign last = (count == TOP);

   // R6: each accepted step advances the index by exactly one
   p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/romix_ctrl.sv
module romix_ctrl #(
   parameter int BLK_W      = 1024,
   parameter int LOG_N      = 10,
   parameter int IDX_LSB    = 480,
   parameter bit FOLD_STAGE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [BLK_W-1:0] blk_in,
   output logic             done,
   output logic [BLK_W-1:0] blk_out,
   output logic             mix_req,
   output logic [BLK_W-1:0] mix_data,
   input  logic             mix_ack,
   input  logic [BLK_W-1:0] mix_res
);
   import romix_pkg::*;

   localparam int IDX_MSB = IDX_LSB + LOG_N - 1;

   if (IDX_MSB >= BLK_W) begin : g_bad_index
      $error("romix_ctrl: index slice exceeds block width");
   end
   if (LOG_N < 1) begin : g_bad_depth
      $error("romix_ctrl: LOG_N must be positive");
   end

   romix_fsm_e       fsm_q, fsm_d;
   logic [BLK_W-1:0] state_q;
   logic [BLK_W-1:0] rdata;
   logic [LOG_N-1:0] step;
   logic             step_last;
   logic             ack_ok;
   logic             cnt_clr;
   logic             go;

   assign go      = (fsm_q == ST_IDLE) && start;
   assign mix_req = (fsm_q == ST_FILL) || (fsm_q == ST_MIX);
   assign ack_ok  = mix_req && mix_ack;
   assign cnt_clr = go || ((fsm_q == ST_FILL) && ack_ok && step_last);
   assign done    = (fsm_q == ST_DONE);
   assign blk_out = state_q;

   always_comb begin
      fsm_d = fsm_q;
      unique case (fsm_q)
         ST_IDLE: if (start) fsm_d = ST_FILL;
         ST_FILL: if (ack_ok && step_last) fsm_d = ST_ADDR;
         ST_ADDR: fsm_d = FOLD_STAGE ? ST_FOLD : ST_MIX;
         ST_FOLD: fsm_d = ST_MIX;
         ST_MIX:  if (ack_ok) fsm_d = step_last ? ST_DONE : ST_ADDR;
         ST_DONE: fsm_d = ST_IDLE;
         default: fsm_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fsm_q <= ST_IDLE;
      else        fsm_q <= fsm_d;
   end

   if (FOLD_STAGE) begin : g_fold_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 state_q <= '0;
         else if (go)                state_q <= blk_in;
         else if (ack_ok)            state_q <= mix_res;
         else if (fsm_q == ST_FOLD)  state_q <= state_q ^ rdata;
      end
      assign mix_data = state_q;
   end else begin : g_fold_comb
      logic rd_phase;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       state_q <= '0;
         else if (go)      state_q <= blk_in;
         else if (ack_ok)  state_q <= mix_res;
      end
      assign rd_phase = (fsm_q == ST_MIX);
      assign mix_data = rd_phase ? (state_q ^ rdata) : state_q;
   end

   romix_step_counter #(.AW(LOG_N)) u_step (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (ack_ok),
      .count (step),
      .last  (step_last)
   );

   romix_scratchpad #(.DW(BLK_W), .AW(LOG_N)) u_pad (
      .clk   (clk),
      .we    ((fsm_q == ST_FILL) && ack_ok),
      .waddr (step),
      .wdata (state_q),
      .rd_en (fsm_q == ST_ADDR),
      .raddr (state_q[IDX_MSB:IDX_LSB]),
      .rdata (rdata)
   );

   // R9: request held with steady data until acknowledged
   p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mix_req && !mix_ack) |=> (mix_req && $stable(mix_data)));

   // R7: completion is a single-cycle pulse
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6: completion directly follows an accepted acknowledge
   p_done_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(mix_req && mix_ack));

   // R1: no request or completion while waiting for start
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(start) && $past(fsm_q == ST_IDLE)) |-> (!mix_req && !done));

   // R8: result held while idle without a new start
   p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((fsm_q == ST_IDLE) && !start) |=> $stable(blk_out));

   // R10: start during the filling phase does not reload the state
   p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((fsm_q == ST_FILL) && start && !mix_ack) |=> $stable(blk_out));
endmodule

// File: tb/romix_ctrl_bench.sv
module romix_ctrl_bench;
   localparam int W  = 1024;
   localparam int NN = 1024;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] blk_in = '0;
   logic         done;
   logic [W-1:0] blk_out;
   logic         mix_req;
   logic [W-1:0] mix_data;
   logic         mix_ack = 1'b0;
   logic [W-1:0] mix_res = '0;

   int compared = 0;
   int mismatched = 0;
   int ack_mode = 0;
   int req_idx = 0;
   logic [W-1:0] exp_q [$];
   logic [W-1:0] pad_m [NN];

   always #4 clk = ~clk;

   romix_ctrl u_romix_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .blk_in(blk_in),
      .done(done), .blk_out(blk_out), .mix_req(mix_req),
      .mix_data(mix_data), .mix_ack(mix_ack), .mix_res(mix_res)
   );

   function automatic logic [W-1:0] mixf(input logic [W-1:0] x);
      logic [W-1:0] t;
      t = {x[1012:0], x[1023:1013]} ^ {x[511:0], x[1023:512]};
      t = t + {x[63:0], 960'd0} + 1024'h1F3D5B79;
      return t ^ (x >> 3);
   endfunction

   function automatic logic [W-1:0] seed_blk(input int k);
      logic [W-1:0] b;
      for (int w = 0; w < 32; w++) b[w*32 +: 32] = (32'h9E3779B9 * (w + 1)) ^ k;
      return b;
   endfunction

   task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h", req, act[63:0], exp[63:0]);
      end
   endtask

   function automatic logic [W-1:0] build_expect(input logic [W-1:0] b);
      logic [W-1:0] x, y;
      x = b;
      for (int i = 0; i < NN; i++) begin
         pad_m[i] = x;
         exp_q.push_back(x);
         x = mixf(x);
      end
      for (int j = 0; j < NN; j++) begin
         y = x ^ pad_m[x[489:480]];
         exp_q.push_back(y);
         x = mixf(y);
      end
      return x;
   endfunction

   // BlockMix responder and request monitor
   initial begin
      forever begin
         @(negedge clk);
         if (mix_req) begin
            logic [W-1:0] seen;
            logic [W-1:0] want;
            int dly;
            string tag;
            seen = mix_data;
            tag = (req_idx == 0) ? "R2" : (req_idx < NN) ? "R3" : "R4/R5";
            if (exp_q.size() == 0) begin
               check(1'b0, "R6 extra request", seen, '0);
            end else begin
               want = exp_q.pop_front();
               check(seen === want, tag, seen, want);
            end
            req_idx++;
            dly = (ack_mode == 0) ? 0 : (ack_mode == 2) ? 2 : $urandom_range(0, 3);
            for (int d = 0; d < dly; d++) begin
               @(negedge clk);
               check(mix_req === 1'b1 && mix_data === seen, "R9", mix_data, seen);
            end
            mix_res = mixf(seen);
            mix_ack = 1'b1;
            @(negedge clk);
            mix_ack = 1'b0;
         end
      end
   end

   task automatic run_op(input logic [W-1:0] b, input int mode, input bit poke);
      logic [W-1:0] fin;
      logic [W-1:0] held;
      int guard;
      exp_q.delete();
      req_idx = 0;
      ack_mode = mode;
      fin = build_expect(b);
      @(negedge clk);
      blk_in = b;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         repeat (20) @(negedge clk);
         blk_in = ~b;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      guard = 0;
      while (done !== 1'b1 && guard < 60000) begin
         @(negedge clk);
         guard++;
      end
      check(done === 1'b1, "R6 done seen", {1023'd0, done}, 1);
      check(blk_out === fin, poke ? "R10 result" : (mode == 1 ? "R11 result" : "R6 result"),
            blk_out, fin);
      check(exp_q.size() == 0 && req_idx == 2 * NN, "R6 request count", req_idx, 2 * NN);
      held = blk_out;
      @(negedge clk);
      check(done === 1'b0, "R7", {1023'd0, done}, 0);
      blk_in = seed_blk(777);
      repeat (6) @(negedge clk);
      check(blk_out === held && done === 1'b0 && mix_req === 1'b0, "R8", blk_out, held);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(done === 1'b0 && mix_req === 1'b0, "R1 reset", {1022'd0, done, mix_req}, 0);
      rst_n = 1'b1;
      blk_in = seed_blk(5);
      repeat (4) @(negedge clk);
      check(done === 1'b0 && mix_req === 1'b0, "R1 idle", {1022'd0, done, mix_req}, 0);
      run_op(seed_blk(1), 0, 1'b0);
      run_op(seed_blk(1), 1, 1'b0);
      run_op(seed_blk(2), 2, 1'b1);
      run_op('0, 1, 1'b0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      compared++;
      mismatched++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule